// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block decides, for a simple processor, when a device interrupt is taken and which one. Each device request line is tied at build time to one of eight strong levels, and several devices may share a level. The controller keeps the processor's current priority, a 3-bit field where 0 means ordinary program execution. At every instruction boundary it finds the highest level among the pending devices. It accepts an interrupt only when that level is strictly above the current priority. In the same cycle it reports the chosen device and its level.

On acceptance the current priority and the exception return register move onto a small context stack. The priority then takes the accepted level, and the return register takes the interrupted instruction's address plus 4. A higher-level request can therefore preempt a running handler. A request at the same level or below waits until that handler has finished. A return strobe pops the stack, so the interrupted code resumes at its earlier priority with its earlier return address. Among devices that share a level, a fixed chain decides: the lower device index is served first, and it does not preempt its neighbours.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `cur_prio` is 0, `xp_reg` is 0, no device is pending and `take_irq` is low.
- R2: A high `dev_req[d]` at a clock edge marks device d pending. The mark stays after the request drops, until an edge where `dev_ack[d]` is high. At that edge the acknowledge wins over a request, and it clears device d alone.
- R3: `take_irq` is high during a cycle exactly when `boundary` is high, `ret_strobe` is low, and the highest pending level is strictly greater than `cur_prio`. The output follows combinationally within that cycle.
- R4: The device chosen is the pending one with the highest level. Ties go to the lowest index. The level of device d is the field `DEV_PRIO[3d+2:3d]`. By default devices 0–1 are at level 1, device 2 at 2, devices 3–5 at 3, device 6 at 5 and device 7 at 7. `irq_prio` is the chosen device's level.
- R5: After a cycle with `take_irq` high, `cur_prio` equals the accepted level and `xp_reg` equals `pc_in + 4` modulo 2^ADDR_W. With neither an acceptance nor a valid return, both hold their values.
- R6: A pending device at a level above the running handler's preempts it. A device at the same level or below is not taken until a return lowers `cur_prio`.
- R7: A `ret_strobe` with saved context restores the `cur_prio` and `xp_reg` values from just before the latest unreturned acceptance. Nesting is last-in first-out, up to 7 deep.
- R8: A `ret_strobe` when no context is saved changes neither `cur_prio` nor `xp_reg`.
- R9: When `ret_strobe` and `boundary` are high in the same cycle, the return is performed and no interrupt is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | NUM_DEV | Device request lines, level-sensitive |
| dev_ack | input | NUM_DEV | Handler acknowledge, one bit per device |
| boundary | input | 1 | Instruction-boundary strobe |
| ret_strobe | input | 1 | Return-from-handler strobe |
| pc_in | input | ADDR_W | Address of the instruction at the boundary |
| take_irq | output | 1 | Interrupt accepted this cycle |
| irq_dev | output | $clog2(NUM_DEV) | Index of the accepted device |
| irq_prio | output | 3 | Level of the accepted device |
| cur_prio | output | 3 | Current processor priority |
| xp_reg | output | ADDR_W | Exception return register |

## Verification
The bench nests handlers through every distinct level and then unwinds them all. A stack that was not last-in first-out, or that lost an entry, would resume at the wrong priority or return address. It places a request at the level of the running handler, where a design using `>=` instead of `>` would re-enter its own handler. It raises several devices of one level at once, where a broken chain would pick a higher index. It also drives a return with an empty stack, and a return together with a boundary. In those cases a faulty design would underflow the priority or take an interrupt while unwinding. Long constrained-random runs then mix pending requests that have already dropped, acknowledges that collide with requests, and random return addresses.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int PRIO_W = 3;
  localparam int LEVELS = 1 << PRIO_W;
  typedef logic [PRIO_W-1:0] prio_t;

  // strict comparison: an equal level never re-enters its own handler
  function automatic logic preempts(prio_t req_lvl, prio_t run_lvl);
    return req_lvl > run_lvl;
  endfunction
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NUM_DEV = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DEV-1:0] dev_req,
  input  logic [NUM_DEV-1:0] dev_ack,
  output logic [NUM_DEV-1:0] pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend | dev_req) & ~dev_ack;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int                     NUM_DEV  = 8,
  parameter logic [NUM_DEV*PRIO_W-1:0] DEV_PRIO = '0,
  localparam int                    DEV_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic [NUM_DEV-1:0] pend,
  output logic               any,
  output logic [DEV_W-1:0]   win_idx,
  output prio_t              win_prio
);
  always_comb begin
    any      = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (pend[i] && (!any || DEV_PRIO[i*PRIO_W +: PRIO_W] > win_prio)) begin
        any      = 1'b1;
        win_idx  = DEV_W'(i);
        win_prio = DEV_PRIO[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_ctx_stack.sv
module irq_ctx_stack
  import prio_irq_pkg::*;
#(
  parameter int  DEPTH  = 8,
  parameter int  ADDR_W = 32,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  prio_t             push_prio,
  input  logic [ADDR_W-1:0] push_pc,
  output prio_t             top_prio,
  output logic [ADDR_W-1:0] top_pc,
  output logic [CNT_W-1:0]  depth,
  output logic              empty,
  output logic              full
);
  prio_t             prio_mem [DEPTH];
  logic [ADDR_W-1:0] pc_mem   [DEPTH];
  logic [PTR_W-1:0]  top_idx;

  assign empty   = (depth == '0);
  assign full    = (depth == CNT_W'(DEPTH));
  assign top_idx = PTR_W'(depth - CNT_W'(1));
  assign top_prio = empty ? '0 : prio_mem[top_idx];
  assign top_pc   = empty ? '0 : pc_mem[top_idx];

  always_ff @(posedge clk) begin
    if (push && !full) begin
      prio_mem[PTR_W'(depth)] <= push_prio;
      pc_mem[PTR_W'(depth)]   <= push_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                depth <= '0;
    else if (push && !full)    depth <= depth + CNT_W'(1);
    else if (pop && !empty)    depth <= depth - CNT_W'(1);
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int                        NUM_DEV  = 8,
  parameter int                        ADDR_W   = 32,
  parameter logic [NUM_DEV*PRIO_W-1:0] DEV_PRIO = {3'd7, 3'd5, 3'd3, 3'd3, 3'd3, 3'd2, 3'd1, 3'd1},
  localparam int                       DEV_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int                       CNT_W    = $clog2(LEVELS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DEV-1:0] dev_req,
  input  logic [NUM_DEV-1:0] dev_ack,
  input  logic               boundary,
  input  logic               ret_strobe,
  input  logic [ADDR_W-1:0]  pc_in,
  output logic               take_irq,
  output logic [DEV_W-1:0]   irq_dev,
  output logic [PRIO_W-1:0]  irq_prio,
  output logic [PRIO_W-1:0]  cur_prio,
  output logic [ADDR_W-1:0]  xp_reg
);
  logic [NUM_DEV-1:0] pend;
  logic               arb_any;
  logic [DEV_W-1:0]   arb_idx;
  prio_t              arb_prio;
  logic               accept;
  logic               do_ret;
  prio_t              top_prio;
  logic [ADDR_W-1:0]  top_pc;
  logic [CNT_W-1:0]   depth;
  logic               stack_empty;
  logic               stack_full;

  irq_pending #(.NUM_DEV(NUM_DEV)) u_pend (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_ack(dev_ack), .pend(pend)
  );

  irq_arbiter #(.NUM_DEV(NUM_DEV), .DEV_PRIO(DEV_PRIO)) u_arb (
    .pend(pend), .any(arb_any), .win_idx(arb_idx), .win_prio(arb_prio)
  );

  // a return owns the cycle; otherwise a boundary may accept
  assign do_ret = ret_strobe && !stack_empty;
  assign accept = boundary && !ret_strobe && arb_any && preempts(arb_prio, cur_prio);

  irq_ctx_stack #(.DEPTH(LEVELS), .ADDR_W(ADDR_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(accept), .pop(do_ret),
    .push_prio(cur_prio), .push_pc(xp_reg),
    .top_prio(top_prio), .top_pc(top_pc),
    .depth(depth), .empty(stack_empty), .full(stack_full)
  );

  assign take_irq = accept;
  assign irq_dev  = arb_idx;
  assign irq_prio = arb_prio;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_prio <= '0;
      xp_reg   <= '0;
    end else if (do_ret) begin
      cur_prio <= top_prio;
      xp_reg   <= top_pc;
    end else if (accept) begin
      cur_prio <= arb_prio;
      xp_reg   <= pc_in + ADDR_W'(4);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
#(
  parameter int  ADDR_W = 32,
  localparam int CNT_W  = $clog2(LEVELS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              boundary,
  input logic              ret_strobe,
  input logic [ADDR_W-1:0] pc_in,
  input logic              take_irq,
  input logic [PRIO_W-1:0] irq_prio,
  input logic [PRIO_W-1:0] cur_prio,
  input logic [ADDR_W-1:0] xp_reg,
  input logic              do_ret,
  input logic [PRIO_W-1:0] top_prio,
  input logic [ADDR_W-1:0] top_pc,
  input logic [CNT_W-1:0]  depth
);
  assert_take_above_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> irq_prio > cur_prio);

  assert_ret_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (boundary && !ret_strobe));

  assert_prio_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> cur_prio == $past(irq_prio));

  assert_xp_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> xp_reg == $past(pc_in) + ADDR_W'(4));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_irq && !ret_strobe) |=> ($stable(cur_prio) && $stable(xp_reg)));

  assert_ret_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    do_ret |=> (cur_prio == $past(top_prio) && xp_reg == $past(top_pc)));

  assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(LEVELS - 1));

  assert_empty_ret_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe && depth == '0) |=> ($stable(cur_prio) && $stable(xp_reg)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .ret_strobe(ret_strobe),
  .pc_in(pc_in), .take_irq(take_irq), .irq_prio(irq_prio), .cur_prio(cur_prio),
  .xp_reg(xp_reg), .do_ret(do_ret), .top_prio(top_prio), .top_pc(top_pc),
  .depth(depth)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 32;
  localparam int LVL [N] = '{1, 1, 2, 3, 3, 3, 5, 7};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  dev_req = '0;
  logic [N-1:0]  dev_ack = '0;
  logic          boundary = 1'b0;
  logic          ret_strobe = 1'b0;
  logic [AW-1:0] pc_in = '0;
  logic          take_irq;
  logic [2:0]    irq_dev;
  logic [2:0]    irq_prio;
  logic [2:0]    cur_prio;
  logic [AW-1:0] xp_reg;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // bench model state
  bit      m_pend [N];
  int      m_cur;
  logic [AW-1:0] m_xp;
  int      m_sp;
  int      st_prio [8];
  logic [AW-1:0] st_pc [8];

  prio_irq_ctrl #(.NUM_DEV(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_ack(dev_ack),
    .boundary(boundary), .ret_strobe(ret_strobe), .pc_in(pc_in),
    .take_irq(take_irq), .irq_dev(irq_dev), .irq_prio(irq_prio),
    .cur_prio(cur_prio), .xp_reg(xp_reg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // scan from the top index down; ">=" lets the lower index win a tie
  function automatic int pick_dev();
    int best = -1;
    for (int d = N - 1; d >= 0; d--)
      if (m_pend[d] && (best < 0 || LVL[d] >= LVL[best])) best = d;
    return best;
  endfunction

  task automatic model_reset();
    for (int d = 0; d < N; d++) m_pend[d] = 0;
    m_cur = 0; m_xp = '0; m_sp = 0;
  endtask

  // apply one cycle of inputs, check outputs, then advance the model
  task automatic cyc(input string tag, input logic [N-1:0] req, input logic [N-1:0] ack,
                     input bit bnd, input bit ret, input logic [AW-1:0] pc);
    int  w;
    bit  exp_take;
    @(negedge clk);
    dev_req = req; dev_ack = ack; boundary = bnd; ret_strobe = ret; pc_in = pc;
    #1;
    w = pick_dev();
    exp_take = bnd && !ret && (w >= 0) && (LVL[w] > m_cur);
    check(tag, "take_irq", take_irq, exp_take);
    if (exp_take) begin
      check(tag, "irq_dev", irq_dev, w);
      check(tag, "irq_prio", irq_prio, LVL[w]);
    end
    check(tag, "cur_prio", cur_prio, m_cur);
    check(tag, "xp_reg", xp_reg, m_xp);
    for (int d = 0; d < N; d++) m_pend[d] = (m_pend[d] || req[d]) && !ack[d];
    if (ret && m_sp > 0) begin
      m_sp--; m_cur = st_prio[m_sp]; m_xp = st_pc[m_sp];
    end else if (exp_take) begin
      st_prio[m_sp] = m_cur; st_pc[m_sp] = m_xp; m_sp++;
      m_cur = LVL[w]; m_xp = pc + 32'd4;
    end
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, '0, '0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "cur_prio after reset", cur_prio, 0);
    check("R1", "xp_reg after reset", xp_reg, 0);
    check("R1", "take_irq after reset", take_irq, 0);
    cyc("R1", '0, '0, 1'b1, 1'b0, 32'h100);

    // R2: one-cycle request, no boundary for a while, still taken later
    cyc("R2", 8'h01, '0, 1'b0, 1'b0, '0);
    idle("R2", 3);
    cyc("R2", '0, '0, 1'b1, 1'b0, 32'h1000);       // take dev0, level 1
    // request and acknowledge collide: acknowledge wins, neighbour untouched
    cyc("R2", 8'h06, 8'h05, 1'b0, 1'b0, '0);       // dev0 acked, dev2 req+ack, dev1 set
    cyc("R2", '0, '0, 1'b1, 1'b0, 32'h1010);       // dev1 at level 1 == cur: no take (R6)
    cyc("R2", '0, 8'h02, 1'b0, 1'b0, '0);

    // R4 / R6: several level-3 devices plus a level-1 device while at level 1
    cyc("R4", 8'h3A, '0, 1'b0, 1'b0, '0);
    cyc("R4", '0, '0, 1'b1, 1'b0, 32'h2000);       // dev3 preempts (R6)
    cyc("R6", '0, 8'h08, 1'b1, 1'b0, 32'h2004);    // dev4 same level: no re-entry
    cyc("R6", '0, '0, 1'b1, 1'b0, 32'h2008);
    cyc("R7", '0, '0, 1'b0, 1'b1, '0);             // back to level 1
    cyc("R4", '0, '0, 1'b1, 1'b0, 32'h3000);       // dev4 before dev5
    cyc("R4", '0, 8'h10, 1'b0, 1'b1, '0);
    cyc("R4", '0, '0, 1'b1, 1'b0, 32'h3100);       // dev5
    cyc("R4", '0, 8'h20, 1'b0, 1'b1, '0);
    cyc("R8", '0, 8'h02, 1'b0, 1'b1, '0);          // back to 0
    cyc("R8", '0, '0, 1'b0, 1'b1, '0);             // empty: ignored
    cyc("R8", '0, '0, 1'b0, 1'b1, '0);

    // R7: nest through every distinct level, then unwind past empty
    cyc("R7", 8'h01, '0, 1'b1, 1'b0, 32'h4000);
    cyc("R7", '0, '0, 1'b1, 1'b0, 32'h4000);
    cyc("R7", 8'h04, 8'h01, 1'b1, 1'b0, 32'h4100);
    cyc("R7", '0, '0, 1'b1, 1'b0, 32'h4200);
    cyc("R7", 8'h08, 8'h04, 1'b1, 1'b0, 32'h4300);
    cyc("R7", '0, '0, 1'b1, 1'b0, 32'h4400);
    cyc("R7", 8'h40, 8'h08, 1'b1, 1'b0, 32'h4500);
    cyc("R7", '0, '0, 1'b1, 1'b0, 32'h4600);
    cyc("R7", 8'h80, 8'h40, 1'b1, 1'b0, 32'h4700);
    cyc("R7", '0, '0, 1'b1, 1'b0, 32'hFFFF_FFFC);  // wrap of pc + 4
    cyc("R7", '0, 8'h80, 1'b1, 1'b0, 32'h4900);
    for (int i = 0; i < 6; i++) cyc("R7", '0, '0, 1'b0, 1'b1, '0);

    // R9: return and boundary together with a higher request pending
    cyc("R9", 8'h01, '0, 1'b1, 1'b0, 32'h5000);
    cyc("R9", 8'h40, 8'h01, 1'b1, 1'b0, 32'h5000);  // dev0 taken
    cyc("R9", '0, '0, 1'b1, 1'b1, 32'h5100);        // dev6 pending, return wins
    cyc("R9", '0, '0, 1'b1, 1'b0, 32'h5200);        // now dev6 taken
    cyc("R9", '0, 8'h40, 1'b0, 1'b1, '0);
    idle("R9", 2);

    // constrained random mix
    seed = 32'h5EED;
    void'($urandom(seed));
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] rq, ak;
      rq = ($urandom % 4 == 0) ? N'(1 << ($urandom % N)) : '0;
      ak = ($urandom % 3 == 0) ? N'($urandom) & N'($urandom) : '0;
      cyc("R3", rq, ak, ($urandom % 10) < 7, ($urandom % 7) == 0, $urandom & 32'hFFFF_FFFC);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule